// File: doc/BRIEF.md
# Tone Steering and Output Latch

This block sits behind a dual-tone detector and decides when a detected tone pair counts as a character. The detector supplies an early flag that is high while it sees a valid pair, together with the 4-bit code of that pair. The block applies time hysteresis in both directions, using two programmable clock counts. A character registers only after the early flag has stayed high for the tone-present count. It is released only after the flag has stayed low for the tone-absent count. Short bursts of tone and short dropouts inside a tone are therefore both ignored.

On registration the code is written into an output latch and a guard indicator goes high. After a fixed settling delay a delayed-steering flag rises, and it stays up until the pause between characters has been validated. The latched code is always offered on a data word with a separate output-enable, so the chip top can build a three-state bus from it. Power-down stops all timing but keeps the last code.

Top module: `tone_steer`

## Requirements
- R1: A character registers at the clock edge on which the early flag has been sampled high on `present_cnt_i` consecutive edges (a value of 0 acts as 1); the code sampled on that edge is written into the latch.
- R2: `guard_o` goes high on the registration edge and, while the character is held, equals the early flag sampled on the previous edge; it is low whenever no character is held.
- R3: `steer_o` rises `SETTLE_CYC` clock edges after the registration edge, provided the character is still held.
- R4: A held character is released, and `steer_o` cleared, at the edge on which the early flag has been sampled low on `absent_cnt_i` consecutive edges (0 acts as 1); a low run shorter than that leaves `steer_o` high.
- R5: The tone-present and tone-absent counts are independent inputs; either may be the larger.
- R6: The count for the current direction restarts whenever the early flag toggles before the count completes, so two short bursts never add up to a registration.
- R7: `data_o` always carries the latched code and `data_oe_o` follows `oe_i` in the same cycle.
- R8: While the early flag stays low (undetected or inhibited characters), the latch keeps the previously registered code whatever the candidate code is.
- R9: While `pwr_dn_i` is high, the state, the running count, `steer_o` and `guard_o` go to zero on the next edge; the latched code is kept.
- R10: After reset the latch holds 0 and `steer_o` and `guard_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_dn_i | input | 1 | Power-down: stop timing, keep code |
| early_i | input | 1 | Early flag from the tone detector |
| code_i | input | CODE_W | Candidate code of the detected pair |
| present_cnt_i | input | CNT_W | Tone-present guard time in clocks |
| absent_cnt_i | input | CNT_W | Tone-absent guard time in clocks |
| oe_i | input | 1 | Output enable for the data word |
| data_o | output | CODE_W | Latched code |
| data_oe_o | output | 1 | Drive enable for the data word |
| steer_o | output | 1 | Delayed-steering flag |
| guard_o | output | 1 | Guard-time indicator |

## Verification
The bench goes after a burst one clock shorter than the present count and two short bursts split by a one-clock gap; a design that did not restart its count would register a character there. It drops the flag for one clock less than the absent count inside a held tone, which a design that released early would report as a falling steering flag. It runs both orderings of the guard counts, pulls power-down mid-character to confirm that the code survives, and checks that the steering flag appears exactly the settling delay after the latch changes rather than with it.

// File: rtl/tone_steer_pkg.sv
// Shared types for the tone steering block.
package tone_steer_pkg;

    // Steering state: waiting for a tone, or holding a registered character.
    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_HELD = 1'b1
    } steer_state_e;

endpackage

// File: rtl/steer_guard_timer.sv
// Run-length timer for one guard direction.
// Counts consecutive clocks with active_i high and pulses hit_o (combinational)
// on the clock where the run reaches limit_i (0 is treated as 1).
// Assumes: limit_i only changes between runs; clr_i clears the run at once.
module steer_guard_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             active_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             hit_o
);
    logic [CNT_W-1:0] run_q;
    logic [CNT_W:0]   run_inc;
    logic [CNT_W-1:0] eff_limit;

    // Effective limit and completion test for this clock.
    always_comb begin
        eff_limit = (limit_i == '0) ? CNT_W'(1) : limit_i;
        run_inc   = {1'b0, run_q} + (CNT_W+1)'(1);
        hit_o     = active_i && (run_inc >= {1'b0, eff_limit});
    end

    // Run counter: restarts on a toggle, on completion and on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            run_q <= '0;
        end else if (!active_i || hit_o) begin
            run_q <= '0;
        end else begin
            run_q <= run_inc[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/steer_settle_delay.sv
// Settling delay after a latch update.
// start_i loads the delay; flag_o rises SETTLE_CYC clocks later and stays
// high until clr_i. Assumes SETTLE_CYC >= 1 and clr_i wins over start_i.
module steer_settle_delay #(
    parameter int SETTLE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic clr_i,
    output logic flag_o
);
    localparam int SW = $clog2(SETTLE_CYC + 1);

    logic [SW-1:0] left_q;

    // Count down the settle window and raise the flag when it ends.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            left_q <= '0;
            flag_o <= 1'b0;
        end else if (start_i) begin
            left_q <= SW'(SETTLE_CYC);
            flag_o <= 1'b0;
        end else if (left_q != '0) begin
            left_q <= left_q - SW'(1);
            if (left_q == SW'(1)) begin
                flag_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/steer_code_latch.sv
// Output code latch: loads code_i when load_i is high, holds otherwise.
// Assumes: power-down does not touch it; only reset clears it.
module steer_code_latch #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] code_o
);
    // Capture a registered code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o <= '0;
        end else if (load_i) begin
            code_o <= code_i;
        end
    end
endmodule

// File: rtl/tone_steer.sv
// Tone steering and output latch.
// Validates tone duration and inter-digit pause with programmable clock
// counts, latches the code, and produces guard and delayed-steering flags.
// Assumes: early_i and code_i are synchronous to clk; the data word and its
// enable are turned into a three-state bus at the chip top.
module tone_steer
    import tone_steer_pkg::*;
#(
    parameter int CODE_W     = 4,
    parameter int CNT_W      = 16,
    parameter int SETTLE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_dn_i,
    input  logic              early_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [CNT_W-1:0]  present_cnt_i,
    input  logic [CNT_W-1:0]  absent_cnt_i,
    input  logic              oe_i,
    output logic [CODE_W-1:0] data_o,
    output logic              data_oe_o,
    output logic              steer_o,
    output logic              guard_o
);
    steer_state_e     state_q;
    steer_state_e     state_d;
    logic             held;
    logic             dir_active;
    logic [CNT_W-1:0] dir_limit;
    logic             dir_hit;
    logic             reg_evt;
    logic             rel_evt;

    // Select the guard direction from the current state.
    always_comb begin
        held       = (state_q == ST_HELD);
        dir_active = held ? !early_i : early_i;
        dir_limit  = held ? absent_cnt_i : present_cnt_i;
        reg_evt    = dir_hit && !held && !pwr_dn_i;
        rel_evt    = dir_hit && held;
    end

    // Next state of the steering machine.
    always_comb begin
        state_d = state_q;
        if (pwr_dn_i) begin
            state_d = ST_WAIT;
        end else if (reg_evt) begin
            state_d = ST_HELD;
        end else if (rel_evt) begin
            state_d = ST_WAIT;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // Guard indicator: high while a character is held and the tone persists.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_dn_i) begin
            guard_o <= 1'b0;
        end else begin
            guard_o <= (state_d == ST_HELD) && early_i;
        end
    end

    steer_guard_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (pwr_dn_i),
        .active_i (dir_active),
        .limit_i  (dir_limit),
        .hit_o    (dir_hit)
    );

    steer_code_latch #(.CODE_W(CODE_W)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (reg_evt),
        .code_i (code_i),
        .code_o (data_o)
    );

    steer_settle_delay #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (reg_evt),
        .clr_i   (pwr_dn_i || rel_evt),
        .flag_o  (steer_o)
    );

    // Output enable passes straight to the bus driver.
    assign data_oe_o = oe_i;
endmodule

// File: rtl/tone_steer_chk.sv
// Property checker for tone_steer, attached with bind.
module tone_steer_chk #(
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_dn_i,
    input logic              early_i,
    input logic              held,
    input logic [CODE_W-1:0] data_o,
    input logic              steer_o,
    input logic              guard_o
);
    // R1
    latch_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_o != $past(data_o)) |-> (held && !$past(held)));

    // R2
    guard_needs_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        guard_o |-> held);

    // R3
    steer_rise_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(steer_o) |-> (held && $past(held)));

    // R4
    steer_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(steer_o) |-> ($past(!early_i) || $past(pwr_dn_i)));

    // R9
    pwr_dn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn_i |=> (!steer_o && !guard_o && !held && $stable(data_o)));
endmodule

bind tone_steer tone_steer_chk #(.CODE_W(CODE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_dn_i (pwr_dn_i),
    .early_i  (early_i),
    .held     (held),
    .data_o   (data_o),
    .steer_o  (steer_o),
    .guard_o  (guard_o)
);

// File: tb/tb_tone_steer.sv
module tb_tone_steer;
    localparam int CODE_W = 4;
    localparam int CNT_W  = 16;
    localparam int SETTLE = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pwr_dn_i = 1'b0;
    logic              early_i = 1'b0;
    logic [CODE_W-1:0] code_i = '0;
    logic [CNT_W-1:0]  present_cnt_i = 16'd5;
    logic [CNT_W-1:0]  absent_cnt_i = 16'd4;
    logic              oe_i = 1'b1;
    logic [CODE_W-1:0] data_o;
    logic              data_oe_o;
    logic              steer_o;
    logic              guard_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    string phase = "R10";

    // reference model state
    int m_held = 0, m_run = 0, m_latch = 0, m_left = 0, m_steer = 0, m_guard = 0;

    always #4 clk = ~clk;

    tone_steer #(.CODE_W(CODE_W), .CNT_W(CNT_W), .SETTLE_CYC(SETTLE)) dut (
        .clk(clk), .rst_n(rst_n), .pwr_dn_i(pwr_dn_i), .early_i(early_i),
        .code_i(code_i), .present_cnt_i(present_cnt_i), .absent_cnt_i(absent_cnt_i),
        .oe_i(oe_i), .data_o(data_o), .data_oe_o(data_oe_o),
        .steer_o(steer_o), .guard_o(guard_o)
    );

    // Behavioural reference, advanced on every rising edge.
    always @(posedge clk) begin
        int lim;
        int act;
        int hit;
        cycles++;
        if (!rst_n) begin
            m_held = 0; m_run = 0; m_latch = 0; m_left = 0; m_steer = 0; m_guard = 0;
        end else if (pwr_dn_i) begin
            m_held = 0; m_run = 0; m_left = 0; m_steer = 0; m_guard = 0;
        end else begin
            lim = m_held ? int'(absent_cnt_i) : int'(present_cnt_i);
            if (lim == 0) lim = 1;
            act = m_held ? !early_i : early_i;
            hit = 0;
            if (act) begin
                m_run++;
                if (m_run >= lim) begin hit = 1; m_run = 0; end
            end else begin
                m_run = 0;
            end
            if (m_held && m_left > 0) begin
                m_left--;
                if (m_left == 0) m_steer = 1;
            end
            if (hit && !m_held) begin
                m_held = 1; m_latch = int'(code_i); m_left = SETTLE; m_steer = 0;
            end else if (hit && m_held) begin
                m_held = 0; m_left = 0; m_steer = 0;
            end
            m_guard = m_held && early_i;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Compare every output with the model (called just after each falling edge).
    task automatic compare();
        chk({phase, " data"}, int'(data_o), m_latch);
        chk({phase, " oe"}, int'(data_oe_o), int'(oe_i));
        chk({phase, " steer"}, int'(steer_o), m_steer);
        chk({phase, " guard"}, int'(guard_o), m_guard);
    endtask

    task automatic drive(input logic e, input int code, input int n);
        for (int i = 0; i < n; i++) begin
            early_i = e;
            code_i = CODE_W'(code);
            @(negedge clk);
            compare();
        end
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R10: reset state
        chk("R10 data", int'(data_o), 0);
        chk("R10 steer", int'(steer_o), 0);
        chk("R10 guard", int'(guard_o), 0);
        rst_n = 1'b1;

        // R1 / R2 / R3: valid tone with present=5, absent=4
        phase = "R1";
        drive(1'b1, 7, 4);
        chk("R1 not yet", int'(guard_o), 0);
        drive(1'b1, 7, 1);
        chk("R1 code", int'(data_o), 7);
        chk("R2 guard", int'(guard_o), 1);
        chk("R3 steer early", int'(steer_o), 0);
        phase = "R3";
        drive(1'b1, 7, 1);
        chk("R3 steer mid", int'(steer_o), 0);
        drive(1'b1, 7, 1);
        chk("R3 steer up", int'(steer_o), 1);

        // R4: dropout shorter than absent count
        phase = "R4";
        drive(1'b0, 7, 3);
        chk("R4 dropout", int'(steer_o), 1);
        chk("R2 guard low", int'(guard_o), 0);
        drive(1'b1, 7, 2);
        chk("R2 guard back", int'(guard_o), 1);
        drive(1'b0, 7, 4);
        chk("R4 release", int'(steer_o), 0);

        // R6: short burst and split bursts do not register
        phase = "R6";
        drive(1'b1, 3, 4);
        drive(1'b0, 3, 1);
        drive(1'b1, 3, 4);
        drive(1'b0, 3, 2);
        chk("R6 no reg", int'(data_o), 7);
        chk("R6 no steer", int'(steer_o), 0);

        // R8: undetected/inhibited character leaves latch alone
        phase = "R8";
        drive(1'b0, 12, 8);
        chk("R8 hold", int'(data_o), 7);

        // R5: present shorter than absent
        phase = "R5";
        present_cnt_i = 16'd2;
        absent_cnt_i = 16'd6;
        drive(1'b1, 10, 2);
        chk("R5 code", int'(data_o), 10);
        drive(1'b1, 10, 2);
        chk("R5 steer", int'(steer_o), 1);
        drive(1'b0, 10, 5);
        chk("R5 hold", int'(steer_o), 1);
        drive(1'b0, 10, 1);
        chk("R5 release", int'(steer_o), 0);

        // R1: zero present count acts as one
        phase = "R1";
        present_cnt_i = 16'd0;
        absent_cnt_i = 16'd0;
        drive(1'b1, 9, 1);
        chk("R1 zero count", int'(data_o), 9);
        drive(1'b0, 9, 2);

        // R7: output enable
        phase = "R7";
        oe_i = 1'b0;
        drive(1'b0, 9, 1);
        chk("R7 oe low", int'(data_oe_o), 0);
        chk("R7 data kept", int'(data_o), 9);
        oe_i = 1'b1;
        drive(1'b0, 9, 1);
        chk("R7 oe high", int'(data_oe_o), 1);

        // R9: power-down mid-character
        phase = "R9";
        present_cnt_i = 16'd3;
        absent_cnt_i = 16'd3;
        drive(1'b1, 5, 6);
        chk("R9 pre steer", int'(steer_o), 1);
        pwr_dn_i = 1'b1;
        drive(1'b1, 5, 2);
        chk("R9 steer off", int'(steer_o), 0);
        chk("R9 guard off", int'(guard_o), 0);
        chk("R9 code kept", int'(data_o), 5);
        pwr_dn_i = 1'b0;
        drive(1'b1, 6, 2);
        chk("R9 restart", int'(data_o), 5);
        drive(1'b1, 6, 1);
        chk("R9 reregister", int'(data_o), 6);
        drive(1'b0, 6, 4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        #(8 * 20000);
        failures++;
        $display("FAIL watchdog R10 actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule